// File: doc/BRIEF.md
# Triangle Spread-Spectrum Division Generator

This block sits in the feedback path of a fractional-N synthesizer, upstream of the sigma-delta modulator. Every divided-reference cycle it produces one signed loop-division word: the integer field times 18432, plus the fractional field, plus a modulation offset. When modulation runs, the offset follows a triangle ramp, so the synthesized frequency sweeps back and forth across a band and its spectral energy spreads out. The ramp rises for a programmed number of steps and then falls for the same number. Each step moves the offset by a programmed step size.

Two spread shapes exist. Centre-spread is symmetric about the nominal value. Down-spread sits entirely at or below it. Modulation turns off whenever the synthesizer is powered down, the sigma-delta path is disabled, the modulation is bypassed, or the programmed settings are illegal. In those cases the block passes the nominal value through unchanged. It raises an error flag whenever the settings are illegal.

Top module: `ssm_triangle_gen`

## Requirements
- R1: While modulation is inactive, `divValue` one cycle after an edge equals intDiv×18432 + fracDiv as sampled at that edge.
- R2: Modulation is active at an edge only when powerDown=0, sdmEnable=1, modBypass=0, the configuration is legal and stepCount is not 0. Otherwise the offset is 0 and the step index returns to 0, rising.
- R3: The configuration is illegal when stepCount×stepSize ≥ 18432 or fracDiv ≥ 18432. `cfgError` is a registered copy of that condition. A product of exactly 18431 is legal.
- R4: With downSpread=0 (centre), let P = stepCount×stepSize and H = floor(P/2). The offset at step index k is k×stepSize − H, capped at +H.
- R5: The step index runs 0,1,…,N,N−1,…,1,0,1,… with one step per cycle while active, giving a period of 2×stepCount cycles.
- R6: With downSpread=1, the offset at step index k is k×stepSize − P, so it spans −P to 0.
- R7: At an edge where stepCount, stepSize or downSpread differs from its value at the previous edge, the ramp restarts. That edge uses step index 0, and the following step rises.
- R8: Synchronous reset (rst=1) clears `divValue` and `cfgError` to 0 and sets the step index to 0 with the direction rising.
- R9: The first active edge after any inactive edge uses step index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided reference clock |
| rst | input | 1 | Synchronous reset, active high |
| intDiv | input | MFI_W | Integer part of the division factor |
| fracDiv | input | FRAC_W | Fraction numerator over 18432 |
| stepCount | input | STEPNO_W | Steps per ramp half-period |
| stepSize | input | STEPSIZE_W | Offset change per step, in 1/18432 units |
| modBypass | input | 1 | 1 bypasses the modulation |
| downSpread | input | 1 | 0 selects centre-spread, 1 selects down-spread |
| sdmEnable | input | 1 | Sigma-delta path enable |
| powerDown | input | 1 | Synthesizer power-down |
| divValue | output | OUT_W | Signed division word in 1/18432 units |
| cfgError | output | 1 | Illegal-configuration flag |

## Verification
The bench first targets an odd step product. There the top of the centre ramp must be clamped to +floor(P/2). A design without the clamp overshoots by one LSB, and a design that rounds the half the other way shifts the whole sweep. The bench then probes the legality boundary at products 18431 and 18432. A comparison with the wrong strictness either modulates an illegal setting or refuses a legal one. Next it changes step size, step count and spread type mid-ramp. A design that does not restart carries a stale index, which can exceed the new count and walk off the band. Finally, every gate that disables modulation is toggled mid-ramp, and the bench expects the sweep to resume from index 0. A design that keeps the old index resumes at a stale offset.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

  // Fixed denominator of the fractional loop division factor
  localparam int FRAC_DEN = 18432;

  // Strobes from control to datapath
  typedef struct packed {
    logic modActive;
    logic downMode;
  } ssm_ctrl_t;

endpackage

// File: rtl/ssm_ctrl.sv
module ssm_ctrl #(
  parameter int FRAC_W     = 15,
  parameter int STEPNO_W   = 12,
  parameter int STEPSIZE_W = 12,
  localparam int PROD_W    = STEPNO_W + STEPSIZE_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [FRAC_W-1:0]     fracDiv,
  input  logic [STEPNO_W-1:0]   stepCount,
  input  logic [STEPSIZE_W-1:0] stepSize,
  input  logic                  modBypass,
  input  logic                  downSpread,
  input  logic                  sdmEnable,
  input  logic                  powerDown,
  output ssm_pkg::ssm_ctrl_t    ctrl,
  output logic [STEPNO_W-1:0]   effIdx,
  output logic [PROD_W-1:0]     prodVal,
  output logic                  cfgError
);

  logic [STEPNO_W-1:0]   stepIdx;
  logic                  rising;
  logic [STEPNO_W-1:0]   prevCount;
  logic [STEPSIZE_W-1:0] prevSize;
  logic                  prevDown;
  logic                  cfgBad;
  logic                  restart;
  logic [STEPNO_W-1:0]   nextIdx;
  logic                  nextRising;

  always_comb begin
    prodVal = PROD_W'(stepCount) * PROD_W'(stepSize);
    cfgBad  = (prodVal >= PROD_W'(ssm_pkg::FRAC_DEN)) ||
              (fracDiv >= FRAC_W'(ssm_pkg::FRAC_DEN));
    restart = (stepCount != prevCount) || (stepSize != prevSize) ||
              (downSpread != prevDown);
    effIdx  = restart ? '0 : stepIdx;
    ctrl.modActive = !powerDown && sdmEnable && !modBypass && !cfgBad &&
                     (stepCount != '0);
    ctrl.downMode  = downSpread;
  end

  // Triangle step walk: up to stepCount, back down to zero
  always_comb begin
    nextIdx    = '0;
    nextRising = 1'b1;
    if (ctrl.modActive) begin
      if (restart || rising) begin
        nextIdx    = effIdx + 1'b1;
        nextRising = (nextIdx < stepCount);
      end else begin
        nextIdx    = effIdx - 1'b1;
        nextRising = (nextIdx == '0);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stepIdx   <= '0;
      rising    <= 1'b1;
      prevCount <= '0;
      prevSize  <= '0;
      prevDown  <= 1'b0;
      cfgError  <= 1'b0;
    end else begin
      stepIdx   <= nextIdx;
      rising    <= nextRising;
      prevCount <= stepCount;
      prevSize  <= stepSize;
      prevDown  <= downSpread;
      cfgError  <= cfgBad;
    end
  end

  // Index never exceeds the step count unless a restart is pending
  assert_idx_bound_R5: assert property (@(posedge clk) disable iff (rst)
    !restart |-> stepIdx <= stepCount);

  // An inactive edge returns the walk to its start
  assert_idle_restart_R2: assert property (@(posedge clk) disable iff (rst)
    !ctrl.modActive |=> (stepIdx == '0) && rising);

  // Product at or over the denominator is flagged on the next cycle
  assert_flag_product_R3: assert property (@(posedge clk) disable iff (rst)
    (PROD_W'(stepCount) * PROD_W'(stepSize) >= PROD_W'(ssm_pkg::FRAC_DEN)) |=> cfgError);

endmodule

// File: rtl/ssm_datapath.sv
module ssm_datapath #(
  parameter int MFI_W      = 8,
  parameter int FRAC_W     = 15,
  parameter int STEPNO_W   = 12,
  parameter int STEPSIZE_W = 12,
  localparam int PROD_W    = STEPNO_W + STEPSIZE_W,
  localparam int OFF_W     = PROD_W + 2,
  localparam int OUT_W     = MFI_W + 17
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [MFI_W-1:0]        intDiv,
  input  logic [FRAC_W-1:0]       fracDiv,
  input  logic [STEPSIZE_W-1:0]   stepSize,
  input  ssm_pkg::ssm_ctrl_t      ctrl,
  input  logic [STEPNO_W-1:0]     effIdx,
  input  logic [PROD_W-1:0]       prodVal,
  output logic signed [OUT_W-1:0] divValue
);

  logic signed [OUT_W-1:0] nominalVal;
  logic [PROD_W-1:0]       kProd;
  logic signed [OFF_W-1:0] halfS;
  logic signed [OFF_W-1:0] prodS;
  logic signed [OFF_W-1:0] rampS;
  logic signed [OFF_W-1:0] offset;
  logic signed [OUT_W-1:0] divNext;

  always_comb begin
    nominalVal = OUT_W'(intDiv) * OUT_W'(ssm_pkg::FRAC_DEN) + OUT_W'(fracDiv);
    kProd      = PROD_W'(effIdx) * PROD_W'(stepSize);
    halfS      = $signed(OFF_W'(prodVal >> 1));
    prodS      = $signed(OFF_W'(prodVal));
    rampS      = $signed(OFF_W'(kProd));
  end

  // Offset shape chosen by the spread mode
  always_comb begin
    if (ctrl.downMode) begin
      offset = rampS - prodS;
    end else if (rampS - halfS > halfS) begin
      offset = halfS;
    end else begin
      offset = rampS - halfS;
    end
  end

  always_comb begin
    divNext = ctrl.modActive ? nominalVal + OUT_W'(offset) : nominalVal;
  end

  always_ff @(posedge clk) begin
    if (rst) divValue <= '0;
    else     divValue <= divNext;
  end

  assert_nominal_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !ctrl.modActive |=> divValue == $past(nominalVal));

  assert_centre_band_R4: assert property (@(posedge clk) disable iff (rst)
    (ctrl.modActive && !ctrl.downMode) |-> (offset <= halfS) && (offset >= -halfS));

  assert_down_band_R6: assert property (@(posedge clk) disable iff (rst)
    (ctrl.modActive && ctrl.downMode) |-> (offset <= 0) && (offset >= -prodS));

endmodule

// File: rtl/ssm_triangle_gen.sv
module ssm_triangle_gen #(
  parameter int MFI_W      = 8,
  parameter int FRAC_W     = 15,
  parameter int STEPNO_W   = 12,
  parameter int STEPSIZE_W = 12,
  localparam int PROD_W    = STEPNO_W + STEPSIZE_W,
  localparam int OUT_W     = MFI_W + 17
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [MFI_W-1:0]        intDiv,
  input  logic [FRAC_W-1:0]       fracDiv,
  input  logic [STEPNO_W-1:0]     stepCount,
  input  logic [STEPSIZE_W-1:0]   stepSize,
  input  logic                    modBypass,
  input  logic                    downSpread,
  input  logic                    sdmEnable,
  input  logic                    powerDown,
  output logic signed [OUT_W-1:0] divValue,
  output logic                    cfgError
);

  ssm_pkg::ssm_ctrl_t  ctrl;
  logic [STEPNO_W-1:0] effIdx;
  logic [PROD_W-1:0]   prodVal;

  ssm_ctrl #(
    .FRAC_W(FRAC_W), .STEPNO_W(STEPNO_W), .STEPSIZE_W(STEPSIZE_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .fracDiv(fracDiv), .stepCount(stepCount),
    .stepSize(stepSize), .modBypass(modBypass), .downSpread(downSpread),
    .sdmEnable(sdmEnable), .powerDown(powerDown), .ctrl(ctrl),
    .effIdx(effIdx), .prodVal(prodVal), .cfgError(cfgError)
  );

  ssm_datapath #(
    .MFI_W(MFI_W), .FRAC_W(FRAC_W), .STEPNO_W(STEPNO_W), .STEPSIZE_W(STEPSIZE_W)
  ) u_dp (
    .clk(clk), .rst(rst), .intDiv(intDiv), .fracDiv(fracDiv),
    .stepSize(stepSize), .ctrl(ctrl), .effIdx(effIdx), .prodVal(prodVal),
    .divValue(divValue)
  );

endmodule

// File: tb/ssm_triangle_gen_tb.sv
`timescale 1ns/1ps
module ssm_triangle_gen_tb;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [7:0]         intDiv = '0;
  logic [14:0]        fracDiv = '0;
  logic [11:0]        stepCount = '0;
  logic [11:0]        stepSize = '0;
  logic               modBypass = 1'b0;
  logic               downSpread = 1'b0;
  logic               sdmEnable = 1'b0;
  logic               powerDown = 1'b1;
  logic signed [24:0] divValue;
  logic               cfgError;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model state
  int mk = 0;
  bit mUp = 1;
  int pN = 0, pS = 0;
  bit pD = 0;

  always #2 clk = ~clk;

  ssm_triangle_gen u_dut (
    .clk(clk), .rst(rst), .intDiv(intDiv), .fracDiv(fracDiv),
    .stepCount(stepCount), .stepSize(stepSize), .modBypass(modBypass),
    .downSpread(downSpread), .sdmEnable(sdmEnable), .powerDown(powerDown),
    .divValue(divValue), .cfgError(cfgError)
  );

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // one edge: model computes from inputs present at that edge
  task automatic cycle(string req);
    int n, s, p, h, f, nom, eff, off, expV;
    bit restart, bad, act, up;
    @(posedge clk);
    #1;
    n = int'(stepCount); s = int'(stepSize); f = int'(fracDiv);
    if (rst) begin
      mk = 0; mUp = 1; pN = 0; pS = 0; pD = 0;
      check({req, " reset value"}, int'(divValue), 0);
      check({req, " reset flag"}, int'(cfgError), 0);
      return;
    end
    p = n * s; h = p / 2;
    restart = (n != pN) || (s != pS) || (downSpread != pD);
    eff = restart ? 0 : mk;
    bad = (p >= 18432) || (f >= 18432);
    act = !powerDown && sdmEnable && !modBypass && !bad && (n != 0);
    nom = int'(intDiv) * 18432 + f;
    if (downSpread) off = eff * s - p;
    else begin
      off = eff * s - h;
      if (off > h) off = h;
    end
    expV = act ? nom + off : nom;
    check({req, " value"}, int'(divValue), expV);
    check({req, " flag"}, int'(cfgError), int'(bad));
    if (!act) begin
      mk = 0; mUp = 1;
    end else begin
      up = restart ? 1'b1 : mUp;
      if (up) begin mk = eff + 1; mUp = (mk < n); end
      else begin mk = eff - 1; mUp = (mk == 0); end
    end
    pN = n; pS = s; pD = downSpread;
  endtask

  task automatic run(int cnt, string req);
    for (int i = 0; i < cnt; i++) cycle(req);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    run(3, "R8");
    rst = 1'b0;
    intDiv = 8'd49; fracDiv = 15'd11520; stepCount = 12'd313; stepSize = 12'd44;
    sdmEnable = 1'b1; powerDown = 1'b1;
    run(5, "R1");
    powerDown = 1'b0;
    cycle("R9");
    // R4: first centre point = 914688 - 13772/2
    check("R4 first centre point", int'(divValue), 907802);
    run(700, "R5");
    sdmEnable = 1'b0; run(3, "R2");
    sdmEnable = 1'b1; modBypass = 1'b1; run(3, "R2");
    modBypass = 1'b0; run(10, "R9");
    // R4 odd product 15: -7,-2,3,7(clamped),3,-2,-7
    stepCount = 12'd3; stepSize = 12'd5; run(20, "R4");
    downSpread = 1'b1; run(20, "R6");
    stepCount = 12'd1; run(6, "R5");
    stepCount = 12'd4; stepSize = 12'd100; run(10, "R6");
    stepSize = 12'd90; run(3, "R7");
    downSpread = 1'b0; run(5, "R7");
    stepCount = 12'd9; run(4, "R7");
    stepCount = 12'd18; stepSize = 12'd1024; run(5, "R3");
    stepCount = 12'd7; stepSize = 12'd2633; run(20, "R3");
    downSpread = 1'b1; run(20, "R6");
    fracDiv = 15'd18432; run(3, "R3");
    fracDiv = 15'd100; stepCount = 12'd0; run(3, "R2");
    stepCount = 12'd5; stepSize = 12'd30; downSpread = 1'b0; run(7, "R5");
    powerDown = 1'b1; run(2, "R2");
    powerDown = 1'b0; run(8, "R9");
    intDiv = 8'd0; fracDiv = 15'd10; run(12, "R4");
    rst = 1'b1; run(2, "R8");
    rst = 1'b0; run(6, "R9");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule